// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial side of a small SPI memory. It watches the host's serial clock, chip select, serial input and an active-low pause input, all sampled by a fast local clock. From each selected frame it takes an 8-bit opcode, an address where the command needs one, and data bytes. It hands these to a storage and control core as single-cycle strobes. Read bytes come back from that core, or from a status input, and leave on a serial output with an enable for the tri-state pad.

Input bits are taken on rising serial-clock edges, and output bits change on falling edges. This serves SPI modes 0 and 3. For a 512-byte array, bit 3 of the READ and WRITE opcodes carries the top address bit, and one address byte follows. A hold input pauses a frame at any point while the serial clock is low. The frame later continues from the same bit.

Write-type commands are only confirmed to the core when chip select rises on a whole byte boundary. The core keeps the byte strobes it has seen until this confirmation arrives, and drops them otherwise.

Top module: `spi_mem_front`

## Requirements
- R1: While chip select is high the serial output enable is low and no read-request or write-byte strobe is issued.
- R2: The first 8 bits of a frame are the opcode, taken MSB first on rising serial-clock edges in either mode 0 or mode 3. The opcodes are: read 0x03, write 0x02, set write-enable 0x06, clear write-enable 0x04, read status 0x05, write status 0x01. Bit 3 of the read and write opcodes is address bit 8.
- R3: A frame starts only on a falling edge of chip select, which clears the bit position. Chip select already low at reset release starts nothing, and an aborted partial frame does not shift the next one.
- R4: After a read opcode and address byte, `rd_req_o` pulses with `addr_o` = {opcode bit 3, address byte}. The returned byte is shifted out MSB first, one bit per falling edge, starting on the falling edge after the last address bit.
- R5: A read continues while chip select stays low. Each further byte comes from the next address, and the address wraps from 0x1FF to 0x000.
- R6: The read-status command sends `status_i` repeatedly, sampled anew for each byte.
- R7: After a write opcode and address byte, every completed data byte pulses `wr_valid_o` with `wr_data_o` and its address on `addr_o`. The address increments per byte and wraps at the array top.
- R8: `commit_o` pulses after chip select rises only if the frame ended on a whole byte boundary. A write frame with trailing partial bits gets no commit and no strobe for the partial byte.
- R9: `cmd_o` encodes the frame's command as none 0, read 1, write 2, set-enable 3, clear-enable 4, read-status 5, write-status 6. It is valid with each strobe and with `commit_o`. Set/clear-enable commit on an aligned frame end, and write-status commits after at least one data byte.
- R10: While paused by hold (low while the serial clock is low) the output enable is low, and serial-clock and serial-input transitions are ignored.
- R11: Raising hold while the serial clock is low resumes the frame at the exact bit where it stopped, for input and output alike.
- R12: An unrecognized opcode causes no strobes, no commit and no output for the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Host serial clock |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data from host |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data to host |
| so_en_o | output | 1 | Output pad enable; low means high impedance |
| cmd_o | output | 3 | Decoded command of the current frame |
| commit_o | output | 1 | Confirmation pulse for write-type commands |
| addr_o | output | ADDR_W | Byte address for read requests and write strobes |
| wr_valid_o | output | 1 | Write data byte strobe |
| wr_data_o | output | 8 | Write data byte |
| rd_req_o | output | 1 | Read byte request to the core |
| rd_data_i | input | 8 | Read byte from the core, valid the cycle after the request |
| status_i | input | 8 | Status byte sent by read-status |

## Verification
A wrong bit position or a missed hold freeze shows up within one byte. The next opcode or address decodes wrongly, and the strobe stream on the core side either stops matching the reference event queue or contains an event the reference never expected. A bad address counter or wrap first appears at the next read request or byte strobe. A broken output shifter appears at the very next host sample on a rising edge. A wrong alignment rule is only seen after chip select rises, as a missing or extra commit pulse a few cycles later.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_READ  = 3'd1,
    CMD_WRITE = 3'd2,
    CMD_WREN  = 3'd3,
    CMD_WRDI  = 3'd4,
    CMD_RDSR  = 3'd5,
    CMD_WRSR  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_DONE,
    PH_IGN
  } phase_e;

  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRSR  = 8'h01;

  // bit 3 of read/write opcodes is an address bit when the array exceeds 256 bytes
  function automatic cmd_e decode_op(input logic [7:0] op, input logic hi_in_op);
    logic [7:0] mask;
    mask = hi_in_op ? 8'hF7 : 8'hFF;
    if ((op & mask) == OPC_READ)       return CMD_READ;
    else if ((op & mask) == OPC_WRITE) return CMD_WRITE;
    else if (op == OPC_WREN)           return CMD_WREN;
    else if (op == OPC_WRDI)           return CMD_WRDI;
    else if (op == OPC_RDSR)           return CMD_RDSR;
    else if (op == OPC_WRSR)           return CMD_WRSR;
    else                               return CMD_NONE;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             WIDTH   = 4,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_edge.sv
module spi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic cs_n_s_i,
  input  logic hold_n_s_i,
  output logic act_o,
  output logic paused_o,
  output logic begin_o,
  output logic end_o,
  output logic rise_o,
  output logic fall_o
);

  logic sck_q, cs_n_q, act_q, paused_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      cs_n_q   <= 1'b0;   // a real high level must be seen before a frame can start
      act_q    <= 1'b0;
      paused_q <= 1'b0;
    end else begin
      sck_q  <= sck_s_i;
      cs_n_q <= cs_n_s_i;
      if (cs_n_s_i)    act_q <= 1'b0;
      else if (cs_n_q) act_q <= 1'b1;
      if (cs_n_s_i)     paused_q <= 1'b0;
      else if (!sck_s_i) paused_q <= !hold_n_s_i;
    end
  end

  assign act_o    = act_q;
  assign paused_o = paused_q;
  assign begin_o  = cs_n_q & ~cs_n_s_i;
  assign end_o    = act_q & cs_n_s_i;
  assign rise_o   = act_q & ~paused_q & ~cs_n_s_i & ~sck_q & sck_s_i;
  assign fall_o   = act_q & ~paused_q & ~cs_n_s_i & sck_q & ~sck_s_i;

  // R11: pause state only leaves while the serial clock is low or on deselect
  a_r11_resume_sck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(paused_q) |-> (!$past(sck_s_i) || $past(cs_n_s_i)));

endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              paused_i,
  input  logic              begin_i,
  input  logic              end_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              si_i,
  input  logic [7:0]        rd_data_i,
  input  logic [7:0]        status_i,
  output logic              so_o,
  output logic              so_en_o,
  output cmd_e              cmd_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_valid_o,
  output logic [7:0]        wr_data_o,
  output logic              rd_req_o
);

  localparam logic HI_IN_OP = (ADDR_W > 8);

  phase_e            phase_q;
  cmd_e              cmd_q, cmd_dec;
  logic [2:0]        bit_cnt_q, tx_cnt_q;
  logic [6:0]        rx_q;
  logic [7:0]        rx_n, tx_q, wr_data_q;
  logic [ADDR_W-1:0] addr_q, addr_cap;
  logic              op_hi_q, data_seen_q, rd_phase_q;
  logic              wr_valid_q, rd_req_q, load_q, commit_q, so_q;

  assign rx_n    = {rx_q, si_i};
  assign cmd_dec = decode_op(rx_n, HI_IN_OP);

  if (ADDR_W > 8) begin : g_hi
    assign addr_cap = {op_hi_q, rx_n};
  end else begin : g_lo
    assign addr_cap = rx_n[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_OPC;
      cmd_q       <= CMD_NONE;
      bit_cnt_q   <= '0;
      tx_cnt_q    <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      wr_data_q   <= '0;
      addr_q      <= '0;
      op_hi_q     <= 1'b0;
      data_seen_q <= 1'b0;
      rd_phase_q  <= 1'b0;
      wr_valid_q  <= 1'b0;
      rd_req_q    <= 1'b0;
      load_q      <= 1'b0;
      commit_q    <= 1'b0;
      so_q        <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      rd_req_q   <= 1'b0;
      commit_q   <= 1'b0;
      load_q     <= rd_req_q;
      if (wr_valid_q && cmd_q == CMD_WRITE) addr_q <= addr_q + ADDR_W'(1);
      if (load_q) tx_q <= rd_data_i;

      if (begin_i) begin
        phase_q     <= PH_OPC;
        cmd_q       <= CMD_NONE;
        bit_cnt_q   <= '0;
        tx_cnt_q    <= '0;
        addr_q      <= '0;
        op_hi_q     <= 1'b0;
        data_seen_q <= 1'b0;
        rd_phase_q  <= 1'b0;
      end else if (end_i) begin
        commit_q <= (bit_cnt_q == 3'd0) &&
                    ((((cmd_q == CMD_WRITE) || (cmd_q == CMD_WRSR)) && data_seen_q) ||
                     (((cmd_q == CMD_WREN) || (cmd_q == CMD_WRDI)) && phase_q == PH_DONE));
      end else begin
        if (rise_i) begin
          rx_q      <= rx_n[6:0];
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            unique case (phase_q)
              PH_OPC: begin
                cmd_q   <= cmd_dec;
                op_hi_q <= rx_n[3];
                unique case (cmd_dec)
                  CMD_READ, CMD_WRITE: phase_q <= PH_ADDR;
                  CMD_WRSR:            phase_q <= PH_WDATA;
                  CMD_WREN, CMD_WRDI:  phase_q <= PH_DONE;
                  CMD_RDSR: begin
                    phase_q    <= PH_RDATA;
                    rd_phase_q <= 1'b1;
                    tx_q       <= status_i;
                    tx_cnt_q   <= '0;
                  end
                  default:             phase_q <= PH_IGN;
                endcase
              end
              PH_ADDR: begin
                addr_q <= addr_cap;
                if (cmd_q == CMD_READ) begin
                  phase_q    <= PH_RDATA;
                  rd_phase_q <= 1'b1;
                  rd_req_q   <= 1'b1;
                  tx_cnt_q   <= '0;
                end else begin
                  phase_q <= PH_WDATA;
                end
              end
              PH_WDATA: begin
                wr_valid_q  <= 1'b1;
                wr_data_q   <= rx_n;
                data_seen_q <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        if (fall_i && rd_phase_q) begin
          so_q     <= tx_q[7];
          tx_cnt_q <= tx_cnt_q + 3'd1;
          if (tx_cnt_q == 3'd7 && cmd_q == CMD_RDSR) begin
            tx_q <= status_i;
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
          if (tx_cnt_q == 3'd7 && cmd_q == CMD_READ) begin
            addr_q   <= addr_q + ADDR_W'(1);   // wraps at the array top
            rd_req_q <= 1'b1;
          end
        end
      end
    end
  end

  assign so_o       = so_q;
  assign so_en_o    = act_i & ~paused_i & rd_phase_q;
  assign cmd_o      = cmd_q;
  assign commit_o   = commit_q;
  assign addr_o     = addr_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_data_o  = wr_data_q;
  assign rd_req_o   = rd_req_q;

  // R7: one strobe per completed byte, never back to back
  a_r7_wr_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_q |=> !wr_valid_q);

  // R4: core reads only belong to a read frame
  a_r4_req_only_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_q |-> (cmd_q == CMD_READ));

  // R10: a paused frame keeps its bit position and shift contents
  a_r10_hold_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_i |=> ($stable(bit_cnt_q) && $stable(rx_q)));

endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              si_i,
  input  logic              hold_ni,
  output logic              so_o,
  output logic              so_en_o,
  output logic [2:0]        cmd_o,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_valid_o,
  output logic [7:0]        wr_data_o,
  output logic              rd_req_o,
  input  logic [7:0]        rd_data_i,
  input  logic [7:0]        status_i
);

  localparam int PIN_N = 4;

  logic [PIN_N-1:0] pins_s;
  logic sck_s, cs_n_s, hold_n_s, si_s;
  logic act, paused, frm_begin, frm_end, sck_rise, sck_fall;
  spi_mem_pkg::cmd_e cmd_w;

  spi_sync #(
    .WIDTH  (PIN_N),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0010)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, cs_ni, hold_ni, si_i}),
    .q_o   (pins_s)
  );

  assign {sck_s, cs_n_s, hold_n_s, si_s} = pins_s;

  spi_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (sck_s),
    .cs_n_s_i  (cs_n_s),
    .hold_n_s_i(hold_n_s),
    .act_o     (act),
    .paused_o  (paused),
    .begin_o   (frm_begin),
    .end_o     (frm_end),
    .rise_o    (sck_rise),
    .fall_o    (sck_fall)
  );

  spi_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .paused_i  (paused),
    .begin_i   (frm_begin),
    .end_i     (frm_end),
    .rise_i    (sck_rise),
    .fall_i    (sck_fall),
    .si_i      (si_s),
    .rd_data_i (rd_data_i),
    .status_i  (status_i),
    .so_o      (so_o),
    .so_en_o   (so_en_o),
    .cmd_o     (cmd_w),
    .commit_o  (commit_o),
    .addr_o    (addr_o),
    .wr_valid_o(wr_valid_o),
    .wr_data_o (wr_data_o),
    .rd_req_o  (rd_req_o)
  );

  assign cmd_o = cmd_w;

  // R1: a deselected interface goes dark and quiet on the core side
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s |=> (!so_en_o && !wr_valid_o && !rd_req_o));

endmodule

// File: tb/spi_mem_front_tb_top.sv
module spi_mem_front_tb_top;

  localparam int AW = 9;
  localparam int H  = 8;   // serial half period in sampling clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_en, commit, wr_valid, rd_req;
  logic [2:0] cmd;
  logic [AW-1:0] addr;
  logic [7:0] wr_data, status;
  logic [7:0] core_rd = 8'h00;

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  logic [31:0] exp_q[$];
  logic [16:0] pend_q[$];
  logic [7:0] core_mem [512];
  logic [7:0] ref_mem  [512];
  logic cs_prev = 1'b1;

  always #2ns clk = ~clk;

  spi_mem_front #(.ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si), .hold_ni(hold_n),
    .so_o(so), .so_en_o(so_en), .cmd_o(cmd), .commit_o(commit), .addr_o(addr),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .rd_req_o(rd_req),
    .rd_data_i(core_rd), .status_i(status)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // core model: registered read, buffered writes applied on commit
  always @(posedge clk) begin
    cs_prev <= cs_n;
    if (cs_prev && !cs_n) pend_q.delete();
    if (rd_req) core_rd <= core_mem[addr];
    if (wr_valid) pend_q.push_back({addr, wr_data});
    if (commit && cmd == 3'd2) begin
      foreach (pend_q[i]) core_mem[pend_q[i][16:8]] = pend_q[i][7:0];
      pend_q.delete();
    end
  end

  task automatic obs_evt(input logic [31:0] o);
    logic [31:0] e;
    if (exp_q.size() == 0) begin
      chk(1'b0, cur_req, "unexpected core event", o, 32'h0);
      return;
    end
    e = exp_q.pop_front();
    if (e[31:24] == 8'd4) chk(o[31:24] == 8'd2 && o[7:0] == e[7:0], cur_req, "status write byte", o, e);
    else                  chk(o == e, cur_req, "core event", o, e);
  endtask

  // reference comparison on every clock, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_req)   obs_evt({8'd1, 16'(addr), 8'd0});
      if (wr_valid) obs_evt({8'd2, 16'(addr), wr_data});
      if (commit)   obs_evt({8'd3, 16'd0, 5'd0, cmd});
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_rd(input int a);     exp_q.push_back({8'd1, 16'(a % 512), 8'd0}); endtask
  task automatic push_wr(input int a, input logic [7:0] d); exp_q.push_back({8'd2, 16'(a % 512), d}); endtask
  task automatic push_cm(input logic [2:0] c); exp_q.push_back({8'd3, 16'd0, 5'd0, c}); endtask

  task automatic sbit(input logic b, input bit do_chk, input logic e, input bit pause);
    sck = 1'b0; si = b;
    wait_clk(H);
    if (pause) begin
      hold_n = 1'b0;
      wait_clk(H);
      chk(so_en == 1'b0, "R10", "output enable during hold", so_en, 0);
      for (int k = 0; k < 3; k++) begin
        si = ~si; sck = 1'b1; wait_clk(H);
        chk(so_en == 1'b0, "R10", "output enable during hold", so_en, 0);
        sck = 1'b0; wait_clk(H);
      end
      si = b;
      hold_n = 1'b1;
      wait_clk(H);
    end
    if (do_chk) begin
      chk(so_en == 1'b1, cur_req, "output enable", so_en, 1);
      chk(so == e, cur_req, "serial out bit", so, e);
    end
    sck = 1'b1;
    wait_clk(H);
  endtask

  task automatic sbyte(input logic [7:0] b, input bit do_chk, input logic [7:0] e, input int hold_at);
    for (int i = 0; i < 8; i++) sbit(b[7-i], do_chk, e[7-i], i == hold_at);
  endtask

  task automatic frame_start(input bit mode3);
    sck = mode3;
    wait_clk(H);
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic frame_end(input bit mode3);
    if (!mode3) sck = 1'b0;
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(3 * H);
    chk(exp_q.size() == 0, cur_req, "missing core events", exp_q.size(), 0);
    exp_q.delete();
    chk(so_en == 1'b0, "R1", "output enable while deselected", so_en, 0);
  endtask

  task automatic do_read(input int a, input int n, input int hold_at);
    frame_start(0);
    for (int i = 0; i <= n; i++) push_rd(a + i);
    sbyte(8'h03 | {4'b0, a[8], 3'b0}, 0, 0, -1);
    sbyte(a[7:0], 0, 0, -1);
    for (int i = 0; i < n; i++) sbyte(8'h00, 1, ref_mem[(a + i) % 512], i == 0 ? hold_at : -1);
    frame_end(0);
  endtask

  task automatic do_write(input int a, input int n, input logic [7:0] d0, input int part, input int hold_at);
    frame_start(0);
    for (int i = 0; i < n; i++) push_wr(a + i, d0 + 8'(i * 17));
    if (part == 0 && n > 0) begin
      push_cm(3'd2);
      for (int i = 0; i < n; i++) ref_mem[(a + i) % 512] = d0 + 8'(i * 17);
    end
    sbyte(8'h02 | {4'b0, a[8], 3'b0}, 0, 0, -1);
    sbyte(a[7:0], 0, 0, -1);
    for (int i = 0; i < n; i++) sbyte(d0 + 8'(i * 17), 0, 0, i == 0 ? hold_at : -1);
    for (int i = 0; i < part; i++) sbit(1'b1, 0, 0, 0);
    frame_end(0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      core_mem[i] = 8'(i * 7 + 3);
      ref_mem[i]  = 8'(i * 7 + 3);
    end
    status = 8'hA5;
    // cs held low through reset: no falling edge, no frame (R3)
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    cur_req = "R1";
    chk(so_en == 1'b0, "R1", "reset output enable", so_en, 0);
    chk({commit, wr_valid, rd_req} == 3'b000, "R1", "reset strobes", {commit, wr_valid, rd_req}, 0);

    cur_req = "R3";
    sbyte(8'h06, 0, 0, -1);
    sck = 1'b0;
    wait_clk(H);
    chk(so_en == 1'b0, "R3", "no frame without chip select fall", so_en, 0);
    cs_n = 1'b1;
    wait_clk(3 * H);
    chk(exp_q.size() == 0, "R3", "no events", exp_q.size(), 0);

    // R9 set/clear write enable, R2 mode 3 framing
    cur_req = "R9";
    push_cm(3'd3); frame_start(0); sbyte(8'h06, 0, 0, -1); frame_end(0);
    push_cm(3'd4); frame_start(0); sbyte(8'h04, 0, 0, -1); frame_end(0);
    cur_req = "R2";
    push_cm(3'd3); frame_start(1); sbyte(8'h06, 0, 0, -1); frame_end(1);

    // R7 write across the array top
    cur_req = "R7";
    do_write(32'h1FE, 3, 8'h11, 0, -1);

    // R4/R5 read with address bit 8 in the opcode, wrapping to zero
    cur_req = "R5";
    do_read(32'h1FD, 4, -1);
    cur_req = "R4";
    do_read(32'h0A0, 2, -1);

    // R8 partial trailing byte: strobes for whole bytes only, no commit
    cur_req = "R8";
    do_write(32'h010, 2, 8'hAA, 5, -1);
    do_read(32'h010, 2, -1);

    // R6 status repeats, resampled per byte
    cur_req = "R6";
    frame_start(0);
    sbyte(8'h05, 0, 0, -1);
    sbyte(8'h00, 1, 8'hA5, -1);
    status = 8'h3C;
    sbyte(8'h00, 1, 8'hA5, -1);
    sbyte(8'h00, 1, 8'h3C, -1);
    frame_end(0);

    // R9 write status
    cur_req = "R9";
    exp_q.push_back({8'd4, 16'd0, 8'h8C});
    push_cm(3'd6);
    frame_start(0); sbyte(8'h01, 0, 0, -1); sbyte(8'h8C, 0, 0, -1); frame_end(0);

    // R12 unknown opcode
    cur_req = "R12";
    frame_start(0);
    sbyte(8'hFF, 0, 0, -1);
    sbyte(8'h12, 0, 0, -1);
    sbyte(8'h34, 0, 0, -1);
    chk(so_en == 1'b0, "R12", "no output after unknown opcode", so_en, 0);
    frame_end(0);

    // R3 aborted partial frame does not shift the next one
    cur_req = "R3";
    frame_start(0);
    for (int i = 0; i < 4; i++) sbit(1'b0, 0, 0, 0);
    frame_end(0);
    push_cm(3'd3); frame_start(0); sbyte(8'h06, 0, 0, -1); frame_end(0);

    // R10/R11 hold inside an output byte, an opcode and a write byte
    cur_req = "R11";
    do_read(32'h1FE, 2, 3);
    frame_start(0);
    push_rd(32'h0A1); push_rd(32'h0A2);
    sbyte(8'h03, 0, 0, 2);
    sbyte(8'hA1, 0, 0, -1);
    sbyte(8'h00, 1, ref_mem[32'h0A1], -1);
    frame_end(0);
    do_write(32'h100, 1, 8'h5E, 0, 4);
    do_read(32'h100, 1, -1);

    wait_clk(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule